// File: doc/BRIEF.md
# Luma/Chroma Double-Edge Word Interleaver

This block turns a parallel video stream into a narrow word stream with a forwarded clock. Each input beat carries one 10-bit luma sample and one 10-bit chroma sample. In interleaved mode the beat leaves as two consecutive words, luma first and then chroma. A forwarded clock runs at half the word rate, and each of its edges marks one word. The chroma words of successive beats alternate between the blue-difference (Cb) and red-difference (Cr) components, so the output order is Y0, Cb0, Y1, Cr0, Y2, Cb1 and so on.

The whole block runs from one clock at the word rate. The first edge of each pair of clock edges is the beat edge, and only at that edge are the input and the mode inputs sampled. The `beat_take` output shows when the next edge is a beat edge. Interleaving is allowed only when the link-rate input reports 3G. At any other rate the beat is passed out unchanged on a 20-bit bus, once per beat, and the forwarded clock has one rising edge per beat.

The block also contains a receive-side rebuilder. It watches both edges of the forwarded clock, reassembles the luma/chroma pairs and recovers the Cb/Cr tag, so that a bench can compare the rebuilt beats against the stimulus.

Top module: `lc_ddr_interleaver`

## Requirements
- R1: While `rst` is held high, `out_word`, `out_wide` and `ddr_on` read zero, `rx_valid` is low and `fwd_clk` is held low.
- R2: In interleaved mode, an accepted beat (in_valid high at a beat edge) drives `out_word` to its luma in the cycle after the beat edge, and to its chroma in the following cycle.
- R3: `fwd_clk` changes on the opposite clock phase to `out_word`. It is high while a luma word (or, in pass-through, a new beat) is on the output and low during the second word slot, so it toggles once per word.
- R4: The chroma tag (0 = Cb, 1 = Cr) alternates over accepted interleaved beats. The first accepted beat after reset, or after a switch into interleaved mode, is Cb. The tag is reported on `rx_cr` by the rebuilder.
- R5: When in_valid is low at a beat edge in interleaved mode, the previous luma and chroma words are sent again, and the Cb/Cr tag does not advance.
- R6: Interleaved mode (`ddr_on` = 1) is entered only at a beat edge where both `ddr_req` and `rate_3g` are high. Otherwise the block is in pass-through.
- R7: In pass-through, `out_word` is zero. An accepted beat sets `out_wide` = {luma, chroma} (luma in bits 19:10) in the cycle after the beat edge, and `out_wide` holds when in_valid is low. In interleaved mode `out_wide` is zero.
- R8: A change on `ddr_req` or `rate_3g` between beat edges has no effect on `ddr_on` until the next beat edge.
- R9: After an accepted interleaved beat, the rebuilder pulses `rx_valid` for one cycle, one cycle after the following beat edge, with `rx_luma` and `rx_chroma` equal to that beat's samples. Repeated pairs produce no pulse.
- R10: Data and in_valid presented at a non-beat edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ddr_req | input | 1 | Request for interleaved output |
| rate_3g | input | 1 | Link rate indicator, high for 3G |
| in_valid | input | 1 | Beat present at this beat edge |
| in_luma | input | 10 | Luma sample of the beat |
| in_chroma | input | 10 | Chroma sample of the beat |
| beat_take | output | 1 | Next clock edge is a beat edge |
| ddr_on | output | 1 | Interleaved mode in force |
| fwd_clk | output | 1 | Forwarded half-rate clock |
| out_word | output | 10 | Interleaved word output |
| out_wide | output | 20 | Pass-through bus, luma in 19:10 |
| rx_valid | output | 1 | Rebuilt beat pulse |
| rx_luma | output | 10 | Rebuilt luma |
| rx_chroma | output | 10 | Rebuilt chroma |
| rx_cr | output | 1 | Rebuilt tag, 0 = Cb, 1 = Cr |

## Verification
The hardest situation to reach is a mode change that lands on a beat boundary while beats are in flight. The Cb/Cr phase must restart at Cb on the transmit side. At the same time, the rebuilder must still finish the last interleaved pair sent under the old mode and then drop its own phase. The stimulus flips `rate_3g` in the middle of a beat, which also checks that the change is deferred. It runs pass-through beats, then restores the rate and checks that the next rebuilt tag is Cb. Gaps are placed between interleaved beats so that repeated pairs must not advance the tag.

// File: rtl/lc_ddr_pkg.sv
package lc_ddr_pkg;

  typedef enum logic {
    CHROMA_CB = 1'b0,
    CHROMA_CR = 1'b1
  } chroma_e;

  // interleaving is permitted only on a 3G link
  function automatic logic ddr_allowed(input logic req, input logic rate3g);
    return req & rate3g;
  endfunction

  // Cb/Cr phase step, advances only when a fresh interleaved beat is taken
  function automatic chroma_e next_phase(input chroma_e cur, input logic adv);
    if (!adv) return cur;
    return (cur == CHROMA_CB) ? CHROMA_CR : CHROMA_CB;
  endfunction

endpackage

// File: rtl/lc_ilv_sequencer.sv
module lc_ilv_sequencer
  import lc_ddr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  logic    ddr_req,
  input  logic    rate_3g,
  output logic    beat_edge,
  output logic    take_beat,
  output logic    mode_next,
  output logic    mode_change,
  output logic    ddr_on,
  output chroma_e tag_now
);

  logic    slot_q;
  logic    mode_q;
  chroma_e phase_q;

  assign beat_edge   = ~slot_q;
  assign mode_next   = ddr_allowed(ddr_req, rate_3g);
  assign mode_change = beat_edge & (mode_next != mode_q);
  assign take_beat   = beat_edge & in_valid;
  assign tag_now     = mode_change ? CHROMA_CB : phase_q;
  assign ddr_on      = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= 1'b0;
      mode_q  <= 1'b0;
      phase_q <= CHROMA_CB;
    end else begin
      slot_q <= ~slot_q;
      if (beat_edge) begin
        mode_q  <= mode_next;
        phase_q <= next_phase(tag_now, take_beat & mode_next);
      end
    end
  end

endmodule

// File: rtl/lc_ilv_tx_path.sv
module lc_ilv_tx_path
  import lc_ddr_pkg::*;
#(
  parameter int SW = 10,
  localparam int WW = 2 * SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat_edge,
  input  logic          take_beat,
  input  logic          mode_next,
  input  logic          ddr_on,
  input  chroma_e       tag_now,
  input  logic [SW-1:0] in_luma,
  input  logic [SW-1:0] in_chroma,
  output logic [SW-1:0] out_word,
  output logic [WW-1:0] out_wide,
  output logic          out_is_chroma,
  output logic          out_fresh,
  output chroma_e       out_tag
);

  logic [SW-1:0] hold_y;
  logic [SW-1:0] hold_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word      <= '0;
      out_wide      <= '0;
      hold_y        <= '0;
      hold_c        <= '0;
      out_is_chroma <= 1'b1;
      out_fresh     <= 1'b0;
      out_tag       <= CHROMA_CB;
    end else if (beat_edge) begin
      out_is_chroma <= 1'b0;
      if (take_beat) begin
        hold_y <= in_luma;
        hold_c <= in_chroma;
      end
      if (mode_next) begin
        out_word  <= take_beat ? in_luma : hold_y;
        out_wide  <= '0;
        out_fresh <= take_beat;
        if (take_beat) out_tag <= tag_now;
      end else begin
        out_word  <= '0;
        out_fresh <= 1'b0;
        if (take_beat) out_wide <= {in_luma, in_chroma};
      end
    end else begin
      out_is_chroma <= 1'b1;
      out_word      <= ddr_on ? hold_c : '0;
    end
  end

endmodule

// File: rtl/lc_ilv_fwd_clk.sv
module lc_ilv_fwd_clk (
  input  logic clk,
  input  logic rst,
  input  logic out_is_chroma,
  output logic fwd_clk
);

  // opposite phase to the data register: edges sit mid-word
  always_ff @(negedge clk) begin
    if (rst) fwd_clk <= 1'b0;
    else     fwd_clk <= ~out_is_chroma;
  end

endmodule

// File: rtl/lc_ilv_rx_rebuild.sv
module lc_ilv_rx_rebuild
  import lc_ddr_pkg::*;
#(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_clk,
  input  logic          ddr_on,
  input  logic          fresh,
  input  logic [SW-1:0] word_in,
  output logic          rx_valid,
  output logic [SW-1:0] rx_luma,
  output logic [SW-1:0] rx_chroma,
  output chroma_e       rx_tag
);

  logic          fwd_q;
  logic [SW-1:0] y_hold;
  chroma_e       tag_q;
  logic          rise_seen;
  logic          fall_seen;

  assign rise_seen = fwd_clk & ~fwd_q;
  assign fall_seen = ~fwd_clk & fwd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q     <= 1'b0;
      y_hold    <= '0;
      tag_q     <= CHROMA_CB;
      rx_valid  <= 1'b0;
      rx_luma   <= '0;
      rx_chroma <= '0;
      rx_tag    <= CHROMA_CB;
    end else begin
      fwd_q    <= fwd_clk;
      rx_valid <= 1'b0;
      if (rise_seen) y_hold <= word_in;
      if (fall_seen && ddr_on) begin
        rx_luma   <= y_hold;
        rx_chroma <= word_in;
        rx_valid  <= fresh;
        if (fresh) begin
          rx_tag <= tag_q;
          tag_q  <= next_phase(tag_q, 1'b1);
        end
      end
      if (!ddr_on) tag_q <= CHROMA_CB;
    end
  end

endmodule

// File: rtl/lc_ddr_interleaver.sv
module lc_ddr_interleaver
  import lc_ddr_pkg::*;
#(
  parameter int SW = 10,
  localparam int WW = 2 * SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ddr_req,
  input  logic          rate_3g,
  input  logic          in_valid,
  input  logic [SW-1:0] in_luma,
  input  logic [SW-1:0] in_chroma,
  output logic          beat_take,
  output logic          ddr_on,
  output logic          fwd_clk,
  output logic [SW-1:0] out_word,
  output logic [WW-1:0] out_wide,
  output logic          rx_valid,
  output logic [SW-1:0] rx_luma,
  output logic [SW-1:0] rx_chroma,
  output logic          rx_cr
);

  logic    beat_edge;
  logic    take_beat;
  logic    mode_next;
  logic    mode_change;
  chroma_e tag_now;
  chroma_e chroma_tag;
  logic    out_is_chroma;
  logic    out_fresh;
  chroma_e rx_tag;

  lc_ilv_sequencer seq_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .ddr_req     (ddr_req),
    .rate_3g     (rate_3g),
    .beat_edge   (beat_edge),
    .take_beat   (take_beat),
    .mode_next   (mode_next),
    .mode_change (mode_change),
    .ddr_on      (ddr_on),
    .tag_now     (tag_now)
  );

  lc_ilv_tx_path #(.SW(SW)) tx_i (
    .clk           (clk),
    .rst           (rst),
    .beat_edge     (beat_edge),
    .take_beat     (take_beat),
    .mode_next     (mode_next),
    .ddr_on        (ddr_on),
    .tag_now       (tag_now),
    .in_luma       (in_luma),
    .in_chroma     (in_chroma),
    .out_word      (out_word),
    .out_wide      (out_wide),
    .out_is_chroma (out_is_chroma),
    .out_fresh     (out_fresh),
    .out_tag       (chroma_tag)
  );

  lc_ilv_fwd_clk fwd_i (
    .clk           (clk),
    .rst           (rst),
    .out_is_chroma (out_is_chroma),
    .fwd_clk       (fwd_clk)
  );

  lc_ilv_rx_rebuild #(.SW(SW)) rx_i (
    .clk       (clk),
    .rst       (rst),
    .fwd_clk   (fwd_clk),
    .ddr_on    (ddr_on),
    .fresh     (out_fresh),
    .word_in   (out_word),
    .rx_valid  (rx_valid),
    .rx_luma   (rx_luma),
    .rx_chroma (rx_chroma),
    .rx_tag    (rx_tag)
  );

  assign beat_take = beat_edge;
  assign rx_cr     = rx_tag;

endmodule

// File: rtl/lc_ilv_chk.sv
module lc_ilv_chk
  import lc_ddr_pkg::*;
#(
  parameter int SW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          beat_edge,
  input logic          take_beat,
  input logic          mode_next,
  input logic          mode_change,
  input logic          in_valid,
  input logic          rate_3g,
  input logic [SW-1:0] in_luma,
  input logic [SW-1:0] in_chroma,
  input logic [SW-1:0] out_word,
  input logic [2*SW-1:0] out_wide,
  input logic          fwd_clk,
  input logic          ddr_on,
  input chroma_e       chroma_tag,
  input logic          rx_valid,
  input logic [SW-1:0] rx_luma,
  input logic [SW-1:0] rx_chroma
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (out_word == '0 && out_wide == '0 && !fwd_clk && !ddr_on && !rx_valid));

  // R2
  luma_first_chk: assert property (@(posedge clk) disable iff (rst)
    (take_beat && mode_next) |=> out_word == $past(in_luma));

  // R2
  chroma_second_chk: assert property (@(posedge clk) disable iff (rst)
    (take_beat && mode_next) |=> ##1 out_word == $past(in_chroma, 2));

  // R3
  fwd_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> fwd_clk != $past(fwd_clk));

  // R4
  cb_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_change && take_beat && mode_next) |=> chroma_tag == CHROMA_CB);

  // R5
  gap_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_edge && !in_valid && mode_next && !mode_change) |=> out_word == $past(out_word, 2));

  // R6
  rate_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_edge && !rate_3g) |=> !ddr_on);

  // R7
  pass_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ddr_on |-> out_word == '0);

  // R7
  pass_wide_chk: assert property (@(posedge clk) disable iff (rst)
    (take_beat && !mode_next) |=> out_wide == {$past(in_luma), $past(in_chroma)});

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !beat_edge |=> $stable(ddr_on));

  // R9
  rx_pair_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_chroma == $past(out_word) && rx_luma == $past(out_word, 2)));

endmodule

bind lc_ddr_interleaver lc_ilv_chk #(.SW(SW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .beat_edge   (beat_edge),
  .take_beat   (take_beat),
  .mode_next   (mode_next),
  .mode_change (mode_change),
  .in_valid    (in_valid),
  .rate_3g     (rate_3g),
  .in_luma     (in_luma),
  .in_chroma   (in_chroma),
  .out_word    (out_word),
  .out_wide    (out_wide),
  .fwd_clk     (fwd_clk),
  .ddr_on      (ddr_on),
  .chroma_tag  (chroma_tag),
  .rx_valid    (rx_valid),
  .rx_luma     (rx_luma),
  .rx_chroma   (rx_chroma)
);

// File: tb/lc_ddr_interleaver_tb_top.sv
module lc_ddr_interleaver_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ddr_req = 1'b0;
  logic        rate_3g = 1'b0;
  logic        in_valid = 1'b0;
  logic [9:0]  in_luma = '0;
  logic [9:0]  in_chroma = '0;
  logic        beat_take;
  logic        ddr_on;
  logic        fwd_clk;
  logic [9:0]  out_word;
  logic [19:0] out_wide;
  logic        rx_valid;
  logic [9:0]  rx_luma;
  logic [9:0]  rx_chroma;
  logic        rx_cr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference state built from the requirements
  logic        m_mode = 1'b0;
  logic        m_phase = 1'b0;
  logic [9:0]  m_hy = '0;
  logic [9:0]  m_hc = '0;
  logic [19:0] m_wide = '0;
  logic        p_fresh = 1'b0;
  logic [9:0]  p_y = '0;
  logic [9:0]  p_c = '0;
  logic        p_tag = 1'b0;

  always #4 clk = ~clk;

  lc_ddr_interleaver dut_i (
    .clk(clk), .rst(rst), .ddr_req(ddr_req), .rate_3g(rate_3g),
    .in_valid(in_valid), .in_luma(in_luma), .in_chroma(in_chroma),
    .beat_take(beat_take), .ddr_on(ddr_on), .fwd_clk(fwd_clk),
    .out_word(out_word), .out_wide(out_wide), .rx_valid(rx_valid),
    .rx_luma(rx_luma), .rx_chroma(rx_chroma), .rx_cr(rx_cr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one beat slot pair; entered with the next clock edge being a beat edge
  task automatic run_beat(input logic v, input logic [9:0] y, input logic [9:0] c,
                          input logic chg_mid);
    logic exp_ddr;
    logic [9:0] ew0;
    logic [9:0] ew1;
    in_valid  = v;
    in_luma   = y;
    in_chroma = c;
    exp_ddr = ddr_req & rate_3g;
    if (exp_ddr != m_mode) m_phase = 1'b0;
    m_mode = exp_ddr;
    if (v) begin m_hy = y; m_hc = c; end
    if (exp_ddr) begin
      ew0 = m_hy; ew1 = m_hc; m_wide = '0;
    end else begin
      ew0 = '0; ew1 = '0;
      if (v) m_wide = {y, c};
    end
    @(posedge clk); #2;
    check(out_word == ew0, exp_ddr ? (v ? "R2" : "R5") : "R7", "first word", out_word, ew0);
    check(ddr_on == exp_ddr, "R6", "mode at beat edge", ddr_on, exp_ddr);
    check(out_wide == m_wide, "R7", "wide bus", out_wide, m_wide);
    if (p_fresh) begin
      check(rx_valid == 1'b1, "R9", "rebuilt pulse", rx_valid, 1);
      check(rx_luma == p_y, "R9", "rebuilt luma", rx_luma, p_y);
      check(rx_chroma == p_c, "R9", "rebuilt chroma", rx_chroma, p_c);
      check(rx_cr == p_tag, "R4", "chroma tag", rx_cr, p_tag);
    end else begin
      check(rx_valid == 1'b0, "R9", "no pulse on repeat/pass", rx_valid, 0);
    end
    p_fresh = v & exp_ddr;
    p_y = y; p_c = c; p_tag = m_phase;
    if (p_fresh) m_phase = ~m_phase;
    // non-beat edge stimulus that must be ignored
    in_valid  = 1'b1;
    in_luma   = ~y;
    in_chroma = ~c;
    if (chg_mid) rate_3g = ~rate_3g;
    #4;
    check(fwd_clk == 1'b1, "R3", "fwd high in first slot", fwd_clk, 1);
    @(posedge clk); #2;
    check(out_word == ew1, exp_ddr ? "R10" : "R7", "second word", out_word, ew1);
    check(out_wide == m_wide, "R10", "wide bus held", out_wide, m_wide);
    check(ddr_on == exp_ddr, "R8", "mode held mid beat", ddr_on, exp_ddr);
    check(beat_take == 1'b1, "R3", "beat edge next", beat_take, 1);
    #4;
    check(fwd_clk == 1'b0, "R3", "fwd low in second slot", fwd_clk, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(out_word == '0, "R1", "word in reset", out_word, 0);
    check(out_wide == '0, "R1", "wide in reset", out_wide, 0);
    check(ddr_on == 1'b0, "R1", "mode in reset", ddr_on, 0);
    check(rx_valid == 1'b0, "R1", "rx in reset", rx_valid, 0);
    #4;
    check(fwd_clk == 1'b0, "R1", "fwd in reset", fwd_clk, 0);
    rst = 1'b0;
  endtask

  task automatic t_ddr_stream();
    ddr_req = 1'b1;
    rate_3g = 1'b1;
    run_beat(1'b1, 10'h040, 10'h200, 1'b0);
    run_beat(1'b1, 10'h041, 10'h1F0, 1'b0);
    run_beat(1'b1, 10'h3AC, 10'h155, 1'b0);
    run_beat(1'b1, 10'h0FE, 10'h2AA, 1'b0);
  endtask

  task automatic t_gaps();
    run_beat(1'b1, 10'h123, 10'h321, 1'b0);
    run_beat(1'b0, 10'h3FF, 10'h3FF, 1'b0);
    run_beat(1'b0, 10'h000, 10'h001, 1'b0);
    run_beat(1'b1, 10'h2B4, 10'h0C3, 1'b0);
    run_beat(1'b0, 10'h111, 10'h222, 1'b0);
    run_beat(1'b1, 10'h099, 10'h188, 1'b0);
  endtask

  task automatic t_mode_mid();
    run_beat(1'b1, 10'h1A1, 10'h2B2, 1'b1);
    run_beat(1'b1, 10'h050, 10'h060, 1'b0);
    run_beat(1'b0, 10'h070, 10'h080, 1'b0);
    run_beat(1'b1, 10'h090, 10'h0A0, 1'b1);
    run_beat(1'b1, 10'h301, 10'h302, 1'b0);
    run_beat(1'b1, 10'h303, 10'h304, 1'b0);
  endtask

  task automatic t_pass();
    ddr_req = 1'b0;
    rate_3g = 1'b1;
    run_beat(1'b1, 10'h2C0, 10'h0D0, 1'b0);
    run_beat(1'b0, 10'h2C1, 10'h0D1, 1'b0);
    ddr_req = 1'b1;
    rate_3g = 1'b0;
    run_beat(1'b1, 10'h3E0, 10'h01F, 1'b0);
    ddr_req = 1'b1;
    rate_3g = 1'b1;
    run_beat(1'b1, 10'h0AB, 10'h0CD, 1'b0);
    run_beat(1'b0, 10'h000, 10'h000, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ddr_stream();
    t_gaps();
    t_mode_mid();
    t_pass();
    finish_run();
  end

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule